// File: doc/BRIEF.md
# Matrix LRU Replacement Tracker

This block holds the replacement state of a set-associative cache and names, for any set, the way that was used least recently. For every set it stores a square bit matrix with one row and one column per way. When an access strobe arrives with a set number and a way number, that way becomes the most recently used one in that set. The matrix for that set is updated on the next clock edge. Tag storage, data storage and hit detection are outside the block. The cache controller reports each hit or fill here, and asks for a victim whenever it has to evict.

The update is applied in one clock. The accessed way's row is filled with ones, and in the same step its column is cleared, so the diagonal bit stays zero. The row that is entirely zero belongs to the least recently used way, and it is reported both as a binary way number and as a one-hot vector. The victim query is combinational from the stored state of the queried set. A query made in the same cycle as an access to that set therefore sees the order before the access. Synchronous reset loads a legal starting order into every set: row r holds ones in columns below r, so way 0 is the first victim and the last way is the most recent. An error flag rises if the queried set has no all-zero row. No sequence of accesses can reach that state.

Top module: `lru_matrix_tracker`

## Requirements
- R1: After synchronous reset every set reports way 0 as victim. The starting order from least to most recent is way 0, way 1, ..., way WAYS-1.
- R2: After an access to way j of set s, a query of set s does not report way j, as long as no later access to that set has occurred.
- R3: For each set, the reported victim is the way whose most recent access lies furthest in the past. The reset order counts as accesses in increasing way order.
- R4: An access changes the victim order of the addressed set only. Every other set keeps its order.
- R5: While acc_valid is 0, no set's order changes, whatever values acc_set and acc_way carry.
- R6: The victim outputs follow qry_set in the same cycle without a clock. When an access and a query name the same set in one cycle, the victim reflects the state before that access.
- R7: victim_onehot has exactly one bit set, at bit position victim_way. victim_way is the binary way number.
- R8: victim_err is 1 only when the queried set has no all-zero row. It stays 0 for every state reachable from reset through accesses.
- R9: Accessing the most recently used way of a set again leaves that set's victim and order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | $clog2(SETS) | Set of the access |
| acc_way | input | $clog2(WAYS) | Way that was accessed |
| qry_set | input | $clog2(SETS) | Set whose victim is requested |
| victim_way | output | $clog2(WAYS) | Least recently used way of the queried set |
| victim_onehot | output | WAYS | One-hot form of victim_way |
| victim_err | output | 1 | Queried set has no all-zero row |

## Verification
An access and a victim query can land in the same cycle, either on the same set or on different sets. The bench provokes both cases. It drives access and query together, samples the victim just after the inputs settle and before the clock edge, and expects the order from before the access. It then queries the same set after the edge and expects the updated order. Both samples are judged against a timestamp model of access recency kept in the bench.

// File: rtl/lru_pkg.sv
package lru_pkg;
    localparam int DEF_WAYS = 4;
    localparam int DEF_SETS = 16;

    // Starting order: row r is newer than every lower-numbered way
    function automatic logic start_bit(int row, int col);
        return col < row;
    endfunction
endpackage

// File: rtl/lru_rowcol_update.sv
module lru_rowcol_update #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAYS-1:0] cur_mat,
    input  logic [WAY_W-1:0]          hit_way,
    output logic [WAYS-1:0][WAYS-1:0] nxt_mat
);
    always_comb begin
        for (int r = 0; r < WAYS; r++) begin
            for (int c = 0; c < WAYS; c++) begin
                if (c == int'(hit_way))
                    nxt_mat[r][c] = 1'b0;
                else if (r == int'(hit_way))
                    nxt_mat[r][c] = 1'b1;
                else
                    nxt_mat[r][c] = cur_mat[r][c];
            end
        end
    end
endmodule

// File: rtl/lru_zero_row_find.sv
module lru_zero_row_find #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAYS-1:0] mat,
    output logic [WAY_W-1:0]          way_idx,
    output logic [WAYS-1:0]           way_hot,
    output logic                      none_found
);
    logic [WAYS-1:0] row_zero;

    for (genvar r = 0; r < WAYS; r++) begin : g_row
        assign row_zero[r] = (mat[r] == '0);
    end

    always_comb begin
        way_hot = '0;
        way_idx = '0;
        for (int r = WAYS - 1; r >= 0; r--) begin
            if (row_zero[r]) begin
                way_hot = '0;
                way_hot[r] = 1'b1;
                way_idx = WAY_W'(r);
            end
        end
        none_found = (row_zero == '0);
    end

    // R7: the one-hot output carries a single bit whenever a zero row exists
    always_comb begin
        if (!none_found)
            assert_single_hot_R7: assert ($countones(way_hot) == 1);
    end
endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker
    import lru_pkg::*;
#(
    parameter int WAYS = DEF_WAYS,
    parameter int SETS = DEF_SETS,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] victim_way,
    output logic [WAYS-1:0]  victim_onehot,
    output logic             victim_err
);
    typedef logic [WAYS-1:0][WAYS-1:0] mat_t;
    typedef struct packed {
        mat_t [SETS-1:0] m;
    } state_t;

    state_t state_d, state_q;
    mat_t   upd_mat;

    lru_rowcol_update #(.WAYS(WAYS)) u_update (
        .cur_mat (state_q.m[acc_set]),
        .hit_way (acc_way),
        .nxt_mat (upd_mat)
    );

    lru_zero_row_find #(.WAYS(WAYS)) u_find (
        .mat        (state_q.m[qry_set]),
        .way_idx    (victim_way),
        .way_hot    (victim_onehot),
        .none_found (victim_err)
    );

    always_comb begin
        state_d = state_q;
        if (acc_valid)
            state_d.m[acc_set] = upd_mat;
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int r = 0; r < WAYS; r++)
                    for (int c = 0; c < WAYS; c++)
                        state_d.m[s][r][c] = start_bit(r, c);
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // R1: the cycle after reset every set names way 0
    assert_reset_victim_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> victim_way == '0);

    // R2: a way just accessed is not the victim of its set
    assert_recent_not_victim_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(acc_valid) && qry_set == $past(acc_set)
        |-> victim_way != $past(acc_way));

    // R5: without an access the answer for a fixed query holds
    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(acc_valid) && $stable(qry_set)
        |-> $stable(victim_way));

    // R8: the error flag never rises in reachable states
    assert_no_error_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !victim_err);
endmodule

// File: tb/tb_lru_matrix_tracker.sv
`timescale 1ns/1ps
module tb_lru_matrix_tracker;
    localparam int WAYS = 4;
    localparam int SETS = 16;
    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);

    logic             clk = 1'b0;
    logic             rst;
    logic             acc_valid;
    logic [SET_W-1:0] acc_set;
    logic [WAY_W-1:0] acc_way;
    logic [SET_W-1:0] qry_set;
    logic [WAY_W-1:0] victim_way;
    logic [WAYS-1:0]  victim_onehot;
    logic             victim_err;

    int checks = 0;
    int errors = 0;
    int stamp [SETS][WAYS];
    int tick;
    bit done = 0;

    always #5 clk = ~clk;

    lru_matrix_tracker #(.WAYS(WAYS), .SETS(SETS)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_way(acc_way), .qry_set(qry_set), .victim_way(victim_way),
        .victim_onehot(victim_onehot), .victim_err(victim_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_victim(int s);
        int best = 0;
        for (int w = 1; w < WAYS; w++)
            if (stamp[s][w] < stamp[s][best]) best = w;
        return best;
    endfunction

    function automatic int model_mru(int s);
        int best = 0;
        for (int w = 1; w < WAYS; w++)
            if (stamp[s][w] > stamp[s][best]) best = w;
        return best;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) stamp[s][w] = w;
        tick = WAYS;
    endtask

    // One cycle: drive, sample before the edge, then update the model
    task automatic step(input bit v, input int s, input int w, input int q, input string req);
        int exp;
        @(negedge clk);
        acc_valid = v; acc_set = SET_W'(s); acc_way = WAY_W'(w); qry_set = SET_W'(q);
        #1;
        exp = model_victim(q);
        chk(req, int'(victim_way), exp);
        chk("R7", int'(victim_onehot), 1 << exp);
        chk("R8", int'(victim_err), 0);
        @(posedge clk);
        if (v) begin stamp[s][w] = tick; tick++; end
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < SETS; s++) step(1'b0, 0, 0, s, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        int v0;
        rst = 1'b1; acc_valid = 1'b0; acc_set = '0; acc_way = '0; qry_set = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: every set starts with way 0 as victim
        sweep("R1");

        // R2: the accessed way is never the next victim
        for (int j = 0; j < WAYS; j++) begin
            step(1'b1, 3, j, 0, "R4");
            step(1'b0, 0, 0, 3, "R2");
            chk("R2", int'(victim_way != WAY_W'(j)), 1);
        end

        // R3 and R9: every length-4 access sequence on set 7
        for (int n = 0; n < 256; n++) begin
            int last = 0;
            for (int k = 0; k < 4; k++) begin
                last = (n >> (2 * k)) & 3;
                step(1'b1, 7, last, 7, "R6");
            end
            step(1'b0, 0, 0, 7, "R3");
            v0 = int'(victim_way);
            step(1'b1, 7, model_mru(7), 7, "R9");
            step(1'b0, 0, 0, 7, "R9");
            chk("R9", int'(victim_way), v0);
        end
        sweep("R4");

        // R5: strobe low, address lines wander
        for (int k = 0; k < 64; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b0, int'(lfsr[3:0]), int'(lfsr[5:4]), int'(lfsr[9:6]), "R5");
        end
        sweep("R5");

        // R6 / R3: mixed traffic, query often on the accessed set
        for (int k = 0; k < 3000; k++) begin
            int s, w, q;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = int'(lfsr[3:0]); w = int'(lfsr[5:4]);
            q = lfsr[6] ? s : int'(lfsr[11:8]);
            step(lfsr[7] | lfsr[12], s, w, q, (q == s) ? "R6" : "R3");
        end
        sweep("R4");

        // R1: reset again after traffic
        @(negedge clk); rst = 1'b1; acc_valid = 1'b1;
        @(posedge clk); model_reset();
        @(negedge clk); rst = 1'b0; acc_valid = 1'b0;
        sweep("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule